// File: doc/BRIEF.md
# AXI ID-Qualified Event Strobe Generator

This block sits beside an AXI memory port and watches three of its channels: read address, write address and read data. For each channel it raises a one-cycle strobe whenever a handshake completes (valid and ready both high) and the handshake's transaction ID passes a programmable masked comparison. The strobes feed a bank of performance counters. The read-address strobe goes to counter 2, the write-address strobe to counter 3 and the read-data strobe to counter 4. On each of those counters the strobe is selected as event code 73.

Software sets up the filter through a simple register write port and can read the two configuration words back. One 18-bit mask and one 18-bit ID value are shared by all three filters. Each filter has its own enable bit. Software clears a filter's enable whenever its counter is given an event other than 73, so a disabled filter must stay silent. All strobes are registered and appear in the cycle after the handshake edge.

Top module: `axi_id_event_filter`

## Requirements
- R1: A synchronous active-high reset clears every configuration bit, the read-back data and all three strobes to zero.
- R2: A write to offset 0x00 stores the filter enables and the mask. Bit 31 enables read-address filtering, bit 30 write-address filtering and bit 29 read-data filtering. Bits 17:0 hold the mask. Read-back of 0x00 shows exactly these bits, with every other bit zero.
- R3: A write to offset 0x04 stores the match ID in bits 17:0. Read-back of 0x04 shows those bits, with every other bit zero.
- R4: A read of any other offset returns zero, and a write to any other offset leaves both configuration words unchanged. Read data is registered and appears one cycle after the read address is presented.
- R5: An ID passes when (id AND mask) equals (match ID AND mask). A mask bit of 1 includes that bit in the comparison. With a zero mask, every ID passes.
- R6: The read-transaction strobe is high for one cycle, in the cycle after each read-address handshake whose ID passes, while bit 31 is set.
- R7: The write-transaction strobe is high for one cycle, in the cycle after each write-address handshake whose ID passes, while bit 30 is set.
- R8: The read-beat strobe is high in the cycle after every read-data handshake whose ID passes, while bit 29 is set. Back-to-back beats give back-to-back strobes, one per beat.
- R9: While a filter's enable bit is clear, its strobe stays low whatever the channel does.
- R10: A valid without ready, or a ready without valid, gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | ADDR_W | Register write byte offset |
| cfg_wr_data | input | DATA_W | Register write data |
| cfg_rd_addr | input | ADDR_W | Register read byte offset |
| cfg_rd_data | output | DATA_W | Registered read-back data |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_id | input | ID_W | Read-address transaction ID |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_id | input | ID_W | Write-address transaction ID |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| r_id | input | ID_W | Read-data transaction ID |
| ev_rd_txn | output | 1 | Filtered read-transaction strobe |
| ev_wr_txn | output | 1 | Filtered write-transaction strobe |
| ev_rd_beat | output | 1 | Filtered read-beat strobe |

## Verification
The random traffic runs under several configurations:
- a full mask, so only exact IDs pass;
- a partial mask, where IDs differing only in unmasked bits must still pass;
- a zero mask, where everything passes;
- subsets of the enables, which show that each enable gates only its own strobe.

The random IDs are biased towards passing values, so both hit and miss strobes occur often. Each channel's valid and ready are randomised independently, which exposes strobes raised on a half handshake. Directed cases cover the following:
- a four-beat read burst, which must give four consecutive strobes;
- a single masked-bit mismatch, which must give no strobe;
- read-back of undefined bits and undefined offsets, which must return zero.

// File: rtl/axif_pkg.sv
package axif_pkg;
  // Lane order; lane i is enabled by configuration bit (DATA_W-1-i)
  localparam int LANE_RD_TXN  = 0;
  localparam int LANE_WR_TXN  = 1;
  localparam int LANE_RD_BEAT = 2;
  localparam int NUM_LANES    = 3;

  // Register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_MATCH = 'h04;
endpackage

// File: rtl/axif_cfg_regs.sv
module axif_cfg_regs
  import axif_pkg::*;
#(
  parameter int ID_W   = 18,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANES  = NUM_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  lane_en,
  output logic [ID_W-1:0]   id_mask,
  output logic [ID_W-1:0]   id_value
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);

  logic              hit_ctrl_wr, hit_match_wr;
  logic [DATA_W-1:0] ctrl_view, match_view, rd_next;
  logic [LANES-1:0]  en_from_bus;
  logic              unused_wr_bits;

  assign hit_ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign hit_match_wr = wr_en && (wr_addr == A_MATCH);

  // Enable bits are taken from the top of the word downward
  for (genvar g = 0; g < LANES; g++) begin : g_en_pick
    assign en_from_bus[g] = wr_data[DATA_W-1-g];
  end

  assign unused_wr_bits = ^wr_data[DATA_W-1-LANES:ID_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_en  <= '0;
      id_mask  <= '0;
      id_value <= '0;
    end else begin
      if (hit_ctrl_wr) begin
        lane_en <= en_from_bus;
        id_mask <= wr_data[ID_W-1:0];
      end
      if (hit_match_wr) begin
        id_value <= wr_data[ID_W-1:0];
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    for (int i = 0; i < LANES; i++) begin
      ctrl_view[DATA_W-1-i] = lane_en[i];
    end
    ctrl_view[ID_W-1:0] = id_mask;
    match_view = '0;
    match_view[ID_W-1:0] = id_value;
    if (rd_addr == A_CTRL) begin
      rd_next = ctrl_view;
    end else if (rd_addr == A_MATCH) begin
      rd_next = match_view;
    end else begin
      rd_next = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/axif_lane.sv
module axif_lane #(
  parameter int ID_W = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            vld,
  input  logic            rdy,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] value,
  output logic            pulse
);
  logic hs, id_ok;

  assign hs    = vld && rdy;
  assign id_ok = ((id ^ value) & mask) == '0;

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= en && hs && id_ok;
  end
endmodule

// File: rtl/axi_id_event_filter.sv
module axi_id_event_filter
  import axif_pkg::*;
#(
  parameter int ID_W   = 18,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic [ADDR_W-1:0] cfg_rd_addr,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              ev_rd_txn,
  output logic              ev_wr_txn,
  output logic              ev_rd_beat
);
  logic [NUM_LANES-1:0] lane_en, hs_vld, hs_rdy, lane_pulse;
  logic [ID_W-1:0]      id_mask, id_value;
  logic [ID_W-1:0]      hs_id [NUM_LANES];

  axif_cfg_regs #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(NUM_LANES)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
    .lane_en(lane_en), .id_mask(id_mask), .id_value(id_value)
  );

  assign hs_vld[LANE_RD_TXN]  = ar_valid;
  assign hs_rdy[LANE_RD_TXN]  = ar_ready;
  assign hs_id[LANE_RD_TXN]   = ar_id;
  assign hs_vld[LANE_WR_TXN]  = aw_valid;
  assign hs_rdy[LANE_WR_TXN]  = aw_ready;
  assign hs_id[LANE_WR_TXN]   = aw_id;
  assign hs_vld[LANE_RD_BEAT] = r_valid;
  assign hs_rdy[LANE_RD_BEAT] = r_ready;
  assign hs_id[LANE_RD_BEAT]  = r_id;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    axif_lane #(.ID_W(ID_W)) u_lane (
      .clk(clk), .rst(rst),
      .en(lane_en[g]), .vld(hs_vld[g]), .rdy(hs_rdy[g]), .id(hs_id[g]),
      .mask(id_mask), .value(id_value),
      .pulse(lane_pulse[g])
    );
  end

  assign ev_rd_txn  = lane_pulse[LANE_RD_TXN];
  assign ev_wr_txn  = lane_pulse[LANE_WR_TXN];
  assign ev_rd_beat = lane_pulse[LANE_RD_BEAT];
endmodule

// File: rtl/axif_checker.sv
module axif_checker #(
  parameter int ID_W = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            ar_valid,
  input logic            ar_ready,
  input logic [ID_W-1:0] ar_id,
  input logic            aw_valid,
  input logic            aw_ready,
  input logic [ID_W-1:0] aw_id,
  input logic            r_valid,
  input logic            r_ready,
  input logic [ID_W-1:0] r_id,
  input logic [2:0]      lane_en,
  input logic [ID_W-1:0] id_mask,
  input logic [ID_W-1:0] id_value,
  input logic            ev_rd_txn,
  input logic            ev_wr_txn,
  input logic            ev_rd_beat
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ev_rd_txn && !ev_wr_txn && !ev_rd_beat && lane_en == '0 && id_mask == '0));

  a_r6_rd_txn_hit: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && lane_en[0] && (((ar_id ^ id_value) & id_mask) == '0)) |=> ev_rd_txn);

  a_r7_wr_txn_hit: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && aw_ready && lane_en[1] && (((aw_id ^ id_value) & id_mask) == '0)) |=> ev_wr_txn);

  a_r8_rd_beat_hit: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && lane_en[2] && (((r_id ^ id_value) & id_mask) == '0)) |=> ev_rd_beat);

  a_r5_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    ((((ar_id ^ id_value) & id_mask) != '0)) |=> !ev_rd_txn);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (lane_en == '0) |=> (!ev_rd_txn && !ev_wr_txn && !ev_rd_beat));

  a_r10_no_handshake: assert property (@(posedge clk) disable iff (rst)
    !(r_valid && r_ready) |=> !ev_rd_beat);
endmodule

bind axi_id_event_filter axif_checker #(.ID_W(ID_W)) u_axif_checker (
  .clk(clk), .rst(rst),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
  .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
  .lane_en(lane_en), .id_mask(id_mask), .id_value(id_value),
  .ev_rd_txn(ev_rd_txn), .ev_wr_txn(ev_wr_txn), .ev_rd_beat(ev_rd_beat)
);

// File: tb/axi_id_event_filter_bench.sv
`timescale 1ns/1ps
module axi_id_event_filter_bench;
  localparam int ID_W = 18;
  localparam int AW   = 8;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic [AW-1:0] cfg_wr_addr = '0;
  logic [DW-1:0] cfg_wr_data = '0;
  logic [AW-1:0] cfg_rd_addr = '0;
  logic [DW-1:0] cfg_rd_data;
  logic ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0, r_valid = 0, r_ready = 0;
  logic [ID_W-1:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic ev_rd_txn, ev_wr_txn, ev_rd_beat;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model of configuration
  logic            m_en_rd = 0, m_en_wr = 0, m_en_bt = 0;
  logic [ID_W-1:0] m_mask = '0, m_val = '0;

  always #2.5 clk = ~clk;

  axi_id_event_filter #(.ID_W(ID_W), .ADDR_W(AW), .DATA_W(DW)) u_axi_id_event_filter (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .ev_rd_txn(ev_rd_txn), .ev_wr_txn(ev_wr_txn), .ev_rd_beat(ev_rd_beat)
  );

  function automatic logic id_pass(logic [ID_W-1:0] id);
    return (id & m_mask) == (m_val & m_mask);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [AW-1:0] a, logic [DW-1:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (a == 8'h00) begin
      m_en_rd = d[31]; m_en_wr = d[30]; m_en_bt = d[29]; m_mask = d[ID_W-1:0];
    end else if (a == 8'h04) begin
      m_val = d[ID_W-1:0];
    end
  endtask

  task automatic cfg_read(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    cfg_rd_addr = a;
    @(negedge clk);
    chk(req, cfg_rd_data, exp);
  endtask

  // drive one cycle of channel activity, then check strobes one cycle later
  task automatic step(logic arv, logic arr, logic [ID_W-1:0] ari,
                      logic awv, logic awr, logic [ID_W-1:0] awi,
                      logic rv, logic rr, logic [ID_W-1:0] ri, string ctx);
    logic e_rd, e_wr, e_bt;
    ar_valid = arv; ar_ready = arr; ar_id = ari;
    aw_valid = awv; aw_ready = awr; aw_id = awi;
    r_valid = rv; r_ready = rr; r_id = ri;
    e_rd = m_en_rd && arv && arr && id_pass(ari);
    e_wr = m_en_wr && awv && awr && id_pass(awi);
    e_bt = m_en_bt && rv && rr && id_pass(ri);
    @(negedge clk);
    chk({"R6 ev_rd_txn ", ctx}, DW'(ev_rd_txn), DW'(e_rd));
    chk({"R7 ev_wr_txn ", ctx}, DW'(ev_wr_txn), DW'(e_wr));
    chk({"R8 ev_rd_beat ", ctx}, DW'(ev_rd_beat), DW'(e_bt));
  endtask

  function automatic logic [ID_W-1:0] pick_id();
    logic [ID_W-1:0] rnd;
    rnd = ID_W'($urandom);
    if ($urandom % 4 == 0) return rnd;
    return m_val ^ (rnd & ~m_mask);
  endfunction

  task automatic run_random(int n, string ctx);
    for (int i = 0; i < n; i++) begin
      step($urandom%2==1, $urandom%2==1, pick_id(),
           $urandom%2==1, $urandom%2==1, pick_id(),
           $urandom%2==1, $urandom%2==1, pick_id(), ctx);
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1D5EED);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ev_rd_txn", DW'(ev_rd_txn), '0);
    chk("R1 ev_wr_txn", DW'(ev_wr_txn), '0);
    chk("R1 ev_rd_beat", DW'(ev_rd_beat), '0);
    chk("R1 rd_data", cfg_rd_data, '0);
    rst = 1'b0;
    cfg_read(8'h00, '0, "R1 ctrl word after reset");
    cfg_read(8'h04, '0, "R1 match word after reset");

    // R2/R3: undefined bits read zero
    cfg_write(8'h00, 32'hFFFF_FFFF);
    cfg_read(8'h00, 32'hE003_FFFF, "R2 ctrl readback");
    cfg_write(8'h04, 32'hFFFF_FFFF);
    cfg_read(8'h04, 32'h0003_FFFF, "R3 match readback");
    // R4: other offsets
    cfg_read(8'h08, '0, "R4 undefined offset read");
    cfg_write(8'h08, 32'h0000_0000);
    cfg_write(8'h0C, 32'h0000_0000);
    cfg_read(8'h00, 32'hE003_FFFF, "R4 ctrl unchanged");
    cfg_read(8'h04, 32'h0003_FFFF, "R4 match unchanged");

    // R5: exact match with full mask, single bit miss
    cfg_write(8'h04, 32'h0001_2345);
    cfg_write(8'h00, 32'hE003_FFFF);
    step(1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345, "R5 exact hit");
    step(1,1,18'h12344, 1,1,18'h02345, 1,1,18'h12347, "R5 one-bit miss");
    // R10: half handshakes
    step(1,0,18'h12345, 0,1,18'h12345, 1,0,18'h12345, "R10 half handshake");
    // R8: four-beat burst, R9: other lanes disabled
    cfg_write(8'h00, 32'h2003_FFFF);
    for (int b = 0; b < 4; b++) step(1,1,18'h12345, 1,1,18'h12345, 1,1,18'h12345, "R8 burst R9");
    // R5: zero mask passes all
    cfg_write(8'h00, 32'hE000_0000);
    step(1,1,18'h3FFFF, 1,1,18'h00000, 1,1,18'h2AAAA, "R5 zero mask");

    // random sections
    cfg_write(8'h00, 32'hE003_FFFF); run_random(400, "rand full mask");
    cfg_write(8'h00, 32'hE000_F0F3); cfg_write(8'h04, 32'h0002_A5C1); run_random(400, "rand partial mask");
    cfg_write(8'h00, 32'hE000_0000); run_random(200, "rand zero mask");
    cfg_write(8'h00, 32'h4001_FF00); run_random(400, "rand R9 wr only");
    cfg_write(8'h00, 32'hA000_00FF); run_random(400, "rand R9 rd and beat");
    cfg_write(8'h00, 32'h0003_FFFF); run_random(200, "rand R9 all off");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule